// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the software-facing register file of one DMA channel. A 32-bit bus reaches three words. The first is a command word that stores nothing: each bit written as one fires a single-cycle strobe toward the data path or clears a latched event. The second is a control word. It holds the transfer mode, the direction, burst and FIFO-bypass settings, and eight interrupt enables. Each enable is changed through its own pair of set and clear bits, so software never has to read, modify and write the word back. The third is a status word that latches completion and error events from the data path and summarises the enabled ones into an interrupt.

The data path itself sits outside the block. It appears only as event inputs: transfer done, link complete, ring wrap and transfer error. It receives the block's command strobes and configuration outputs. A channel-running flag is tracked here. While it is set, the control word is locked against writes.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every strobe, `chan_running`, `irq` and the configuration outputs are 0. The control and status words read as 0.
- R2: Writing the command word (word 0) fires one strobe for each bit written as one, in the cycle after the write, for exactly one cycle: bit 0 start, bit 1 continue, bit 2 stop, bit 3 abort, bit 4 FIFO reset, bit 31 channel reset.
- R3: `chan_running` is set by a start or continue command. It is cleared by stop, abort, channel reset or a done event. Channel reset overrides start.
- R4: Events latch into the status word (word 2) and stay set until cleared. Done is bit 25, link complete bit 19, ring wrap bit 17 and transfer error bit 9. Bit 15 reads as a copy of the transfer error flag.
- R5: Command bit 7 clears done, bit 5 clears link complete and bit 6 clears ring wrap. An event arriving in the same cycle as its clear command leaves the flag set. Transfer error is not cleared by these bits.
- R6: Control word (word 1) bits 31..16 form eight enable pairs, set bit above clear bit. Pair k (k = 0..7) uses set bit 17+2k and clear bit 16+2k. The pairs in order k = 7..0 are DMA interrupt, link pause, address stop, done, memory ready, device ready, link complete, ring wrap. A read shows each enable at its set-bit position and 0 at every clear-bit position.
- R7: Writing a set bit and its clear bit together leaves that enable unchanged. Writing neither also leaves it unchanged.
- R8: Control bits 2:0 (mode), bit 3 (device-to-memory), bit 14 (burst) and bit 15 (FIFO off) are stored, read back and drive `cfg_mode`, `cfg_dev_to_mem`, `cfg_burst` and `cfg_fifo_off`. All other control bits read as 0.
- R9: A control write while `chan_running` is 1 changes nothing.
- R10: Status bit 31 and `irq` equal DMA-enable AND ((done AND done-enable) OR (link complete AND link-complete-enable) OR (ring wrap AND ring-enable)).
- R11: A channel reset clears all latched status flags, all eight enables and the running flag. It keeps the mode, direction, burst and FIFO fields.
- R12: Read data appears in the cycle after the read strobe. Word n is selected by `bus_addr` = 4n. The command word and any other address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ev_done | input | 1 | Transfer done event |
| ev_link_done | input | 1 | Link complete event |
| ev_ring | input | 1 | Ring wrap event |
| ev_xfer_err | input | 1 | Transfer error event |
| cmd_start | output | 1 | Start strobe |
| cmd_continue | output | 1 | Continue strobe |
| cmd_stop | output | 1 | Stop-after-drain strobe |
| cmd_abort | output | 1 | Abort strobe |
| cmd_fifo_reset | output | 1 | FIFO reset strobe |
| cmd_chan_reset | output | 1 | Channel reset strobe |
| chan_running | output | 1 | Channel running flag |
| cfg_mode | output | 3 | Transfer mode |
| cfg_dev_to_mem | output | 1 | Direction, 1 = device to memory |
| cfg_burst | output | 1 | Burst enable |
| cfg_fifo_off | output | 1 | FIFO bypass |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong enable shows up at once in the control readback on the next read, and on `irq` as soon as a matching event is latched. For this reason the bench sweeps every set/clear combination against every prior enable value, and every enable mask against every event combination. A command bit decoded to the wrong strobe is visible on the outputs one cycle after the write. A stuck strobe is visible one cycle after that. A lost or early-cleared flag is seen on the first status read after an event, a clear command or a channel reset.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   // command word bit positions
   localparam int OP_START    = 0;
   localparam int OP_CONT     = 1;
   localparam int OP_STOP     = 2;
   localparam int OP_ABORT    = 3;
   localparam int OP_FIFO_RST = 4;
   localparam int OP_CLR_LC   = 5;
   localparam int OP_CLR_RB   = 6;
   localparam int OP_CLR_DONE = 7;
   localparam int OP_CHAN_RST = 31;
   // enable pair indices (pair k: set 17+2k, clear 16+2k)
   localparam int IE_RB    = 0;
   localparam int IE_LC    = 1;
   localparam int IE_DRDY  = 2;
   localparam int IE_MRDY  = 3;
   localparam int IE_DONE  = 4;
   localparam int IE_SAR   = 5;
   localparam int IE_LINKP = 6;
   localparam int IE_DMA   = 7;
   localparam int IE_BASE  = 16;
   // control field positions
   localparam int CT_DIR     = 3;
   localparam int CT_BURST   = 14;
   localparam int CT_FIFODIS = 15;
   // status bit positions
   localparam int ST_INT  = 31;
   localparam int ST_DONE = 25;
   localparam int ST_LC   = 19;
   localparam int ST_RB   = 17;
   localparam int ST_ERR  = 15;
   localparam int ST_XERR = 9;
   // event flag indices
   localparam int EV_DONE = 0;
   localparam int EV_LC   = 1;
   localparam int EV_RB   = 2;
   localparam int EV_XERR = 3;
   localparam int N_EV    = 4;

   typedef struct packed {
      logic start;
      logic cont;
      logic stop;
      logic abort;
      logic fifo_rst;
      logic chan_rst;
      logic clr_done;
      logic clr_lc;
      logic clr_rb;
   } op_cmd_t;

   typedef enum logic [1:0] {
      SEL_OP   = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_STS  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dmach_op_decode.sv
module dmach_op_decode
   import dmach_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_op,
   input  logic [DATA_W-1:0] wdata,
   output op_cmd_t           now,
   output op_cmd_t           pulse
);
   logic unused_op_bits;
   assign unused_op_bits = ^wdata[OP_CHAN_RST-1:OP_CLR_DONE+1];

   always_comb begin
      now          = '0;
      now.start    = wr_op & wdata[OP_START];
      now.cont     = wr_op & wdata[OP_CONT];
      now.stop     = wr_op & wdata[OP_STOP];
      now.abort    = wr_op & wdata[OP_ABORT];
      now.fifo_rst = wr_op & wdata[OP_FIFO_RST];
      now.chan_rst = wr_op & wdata[OP_CHAN_RST];
      now.clr_done = wr_op & wdata[OP_CLR_DONE];
      now.clr_lc   = wr_op & wdata[OP_CLR_LC];
      now.clr_rb   = wr_op & wdata[OP_CLR_RB];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= '0;
      else        pulse <= now;
   end

   // R2: a strobe never lasts beyond the cycle after its write
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse.start && !now.start) |=> !pulse.start);
endmodule

// File: rtl/dmach_ie_bank.sv
module dmach_ie_bank #(
   parameter int N_PAIRS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [N_PAIRS-1:0] set_bits,
   input  logic [N_PAIRS-1:0] clr_bits,
   input  logic               clr_all,
   output logic [N_PAIRS-1:0] ie
);
   for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all)
            ie[k] <= 1'b0;
         else if (wr_en) begin
            case ({set_bits[k], clr_bits[k]})
               2'b10:   ie[k] <= 1'b1;
               2'b01:   ie[k] <= 1'b0;
               default: ie[k] <= ie[k];
            endcase
         end
      end

      // R7: set and clear together leave the enable alone
      p_pair_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && set_bits[k] && clr_bits[k] && !clr_all) |=> $stable(ie[k]));
   end
endmodule

// File: rtl/dmach_status.sv
module dmach_status
   import dmach_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EV-1:0] ev_set,
   input  logic [N_EV-1:0] ev_clr,
   input  logic            clr_all,
   output logic [N_EV-1:0] flags
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) flags <= '0;
      else                   flags <= (flags & ~ev_clr) | ev_set;
   end

   for (genvar i = 0; i < N_EV; i++) begin : g_chk
      // R4: a latched flag persists until an explicit clear
      p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !ev_clr[i] && !clr_all) |=> flags[i]);
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dmach_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int N_PAIRS = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_done,
   input  logic              ev_link_done,
   input  logic              ev_ring,
   input  logic              ev_xfer_err,
   output logic              cmd_start,
   output logic              cmd_continue,
   output logic              cmd_stop,
   output logic              cmd_abort,
   output logic              cmd_fifo_reset,
   output logic              cmd_chan_reset,
   output logic              chan_running,
   output logic [2:0]        cfg_mode,
   output logic              cfg_dev_to_mem,
   output logic              cfg_burst,
   output logic              cfg_fifo_off,
   output logic              irq
);
   localparam int SEL_LO = 2;
   localparam int SEL_HI = SEL_LO + 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("dma_chan_regs: DATA_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("dma_chan_regs: ADDR_W must be at least 4");
   end
   if (IE_BASE + 2 * N_PAIRS != DATA_W) begin : g_bad_pairs
      $error("dma_chan_regs: enable pairs must fill bits 31..16");
   end

   // ---------------- address decode
   reg_sel_e sel;
   always_comb begin
      sel = reg_sel_e'(bus_addr[SEL_HI:SEL_LO]);
      if (bus_addr[SEL_LO-1:0] != '0) sel = SEL_NONE;
      if (ADDR_W > 4) begin
         if ((bus_addr >> 4) != '0) sel = SEL_NONE;
      end
   end

   logic wr_op, wr_ctl;
   assign wr_op  = bus_wr && (sel == SEL_OP);
   assign wr_ctl = bus_wr && (sel == SEL_CTL) && !chan_running;

   // ---------------- command decode
   op_cmd_t now, pulse;
   dmach_op_decode #(.DATA_W(DATA_W)) u_op (
      .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .wdata(bus_wdata),
      .now(now), .pulse(pulse)
   );
   assign cmd_start      = pulse.start;
   assign cmd_continue   = pulse.cont;
   assign cmd_stop       = pulse.stop;
   assign cmd_abort      = pulse.abort;
   assign cmd_fifo_reset = pulse.fifo_rst;
   assign cmd_chan_reset = pulse.chan_rst;

   // ---------------- running state
   always_ff @(posedge clk) begin
      if (!rst_n || now.chan_rst)            chan_running <= 1'b0;
      else if (now.start || now.cont)        chan_running <= 1'b1;
      else if (now.stop || now.abort || ev_done) chan_running <= 1'b0;
   end

   // ---------------- enable pairs
   logic [N_PAIRS-1:0] set_bits, clr_bits, ie;
   always_comb begin
      for (int k = 0; k < N_PAIRS; k++) begin
         set_bits[k] = bus_wdata[IE_BASE + 2*k + 1];
         clr_bits[k] = bus_wdata[IE_BASE + 2*k];
      end
   end

   dmach_ie_bank #(.N_PAIRS(N_PAIRS)) u_ie (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .set_bits(set_bits),
      .clr_bits(clr_bits), .clr_all(now.chan_rst), .ie(ie)
   );

   // ---------------- configuration fields
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode       <= '0;
         cfg_dev_to_mem <= 1'b0;
         cfg_burst      <= 1'b0;
         cfg_fifo_off   <= 1'b0;
      end else if (wr_ctl) begin
         cfg_mode       <= bus_wdata[2:0];
         cfg_dev_to_mem <= bus_wdata[CT_DIR];
         cfg_burst      <= bus_wdata[CT_BURST];
         cfg_fifo_off   <= bus_wdata[CT_FIFODIS];
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata[CT_BURST-1:OP_CLR_DONE+1];

   // ---------------- status flags
   logic [N_EV-1:0] ev_set, ev_clr, flags;
   assign ev_set = {ev_xfer_err, ev_ring, ev_link_done, ev_done};
   assign ev_clr = {1'b0, now.clr_rb, now.clr_lc, now.clr_done};

   dmach_status u_sts (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
      .clr_all(now.chan_rst), .flags(flags)
   );

   logic int_sum;
   assign int_sum = ie[IE_DMA] &
                    ((flags[EV_DONE] & ie[IE_DONE]) |
                     (flags[EV_LC]   & ie[IE_LC])   |
                     (flags[EV_RB]   & ie[IE_RB]));

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= int_sum;
      end
   end else begin : g_irq_comb
      assign irq = int_sum;
   end

   // ---------------- read mux
   logic [DATA_W-1:0] ctl_img, sts_img, rd_mux;
   always_comb begin
      ctl_img = '0;
      for (int k = 0; k < N_PAIRS; k++) ctl_img[IE_BASE + 2*k + 1] = ie[k];
      ctl_img[2:0]        = cfg_mode;
      ctl_img[CT_DIR]     = cfg_dev_to_mem;
      ctl_img[CT_BURST]   = cfg_burst;
      ctl_img[CT_FIFODIS] = cfg_fifo_off;

      sts_img          = '0;
      sts_img[ST_INT]  = int_sum;
      sts_img[ST_DONE] = flags[EV_DONE];
      sts_img[ST_LC]   = flags[EV_LC];
      sts_img[ST_RB]   = flags[EV_RB];
      sts_img[ST_ERR]  = flags[EV_XERR];
      sts_img[ST_XERR] = flags[EV_XERR];

      case (sel)
         SEL_CTL: rd_mux = ctl_img;
         SEL_STS: rd_mux = sts_img;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   // ---------------- assertions
   p_start_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> $past(bus_wr && sel == SEL_OP && bus_wdata[OP_START]));

   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ie[IE_DMA] |-> !int_sum);

   p_ctl_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_running && bus_wr && sel == SEL_CTL) |=> $stable(cfg_mode));

   p_op_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_OP) |=> (bus_rdata == '0));

   p_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && bus_wdata[OP_CHAN_RST]) |=> (!chan_running && flags == '0 && ie == '0));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic ev_done = 1'b0, ev_link_done = 1'b0, ev_ring = 1'b0, ev_xfer_err = 1'b0;
   logic cmd_start, cmd_continue, cmd_stop, cmd_abort, cmd_fifo_reset, cmd_chan_reset;
   logic chan_running, cfg_dev_to_mem, cfg_burst, cfg_fifo_off, irq;
   logic [2:0] cfg_mode;

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   dma_chan_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_done(ev_done), .ev_link_done(ev_link_done), .ev_ring(ev_ring),
      .ev_xfer_err(ev_xfer_err), .cmd_start(cmd_start), .cmd_continue(cmd_continue),
      .cmd_stop(cmd_stop), .cmd_abort(cmd_abort), .cmd_fifo_reset(cmd_fifo_reset),
      .cmd_chan_reset(cmd_chan_reset), .chan_running(chan_running),
      .cfg_mode(cfg_mode), .cfg_dev_to_mem(cfg_dev_to_mem), .cfg_burst(cfg_burst),
      .cfg_fifo_off(cfg_fifo_off), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_ev(input logic [3:0] m);
      @(negedge clk);
      {ev_xfer_err, ev_ring, ev_link_done, ev_done} = m;
      @(negedge clk);
      {ev_xfer_err, ev_ring, ev_link_done, ev_done} = '0;
   endtask

   function automatic logic [5:0] strobes();
      return {cmd_chan_reset, cmd_fifo_reset, cmd_abort, cmd_stop, cmd_continue, cmd_start};
   endfunction

   function automatic logic [31:0] ctl_img(input logic [7:0] ie, input logic [31:0] f);
      logic [31:0] v = f & 32'h0000_C00F;
      for (int k = 0; k < 8; k++) v[17 + 2*k] = ie[k];
      return v;
   endfunction

   initial begin
      int cyc = 0;
      while (!done_flag) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0] exp_ie;
      int bits[6] = '{0, 1, 2, 3, 4, 31};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 strobes", {26'd0, strobes()}, 32'd0);
      chk("R1 running/irq", {30'd0, chan_running, irq}, 32'd0);
      chk("R1 cfg", {26'd0, cfg_mode, cfg_dev_to_mem, cfg_burst, cfg_fifo_off}, 32'd0);
      rd(4'h4, d); chk("R1 ctl", d, 32'd0);
      rd(4'h8, d); chk("R1 sts", d, 32'd0);

      // R2 one strobe per command bit, one cycle long
      for (int i = 0; i < 6; i++) begin
         wr(4'h0, 32'd1 << bits[i]);
         chk("R2 strobe on", {26'd0, strobes()}, 32'd1 << i);
         @(negedge clk);
         chk("R2 strobe off", {26'd0, strobes()}, 32'd0);
      end

      // R12 address map reads
      rd(4'h0, d); chk("R12 op reads 0", d, 32'd0);
      rd(4'hC, d); chk("R12 unmapped reads 0", d, 32'd0);

      // R6 / R7 sweep of every pair, prior value and set/clear combination
      exp_ie = '0;
      for (int k = 0; k < 8; k++) begin
         for (int prior = 0; prior < 2; prior++) begin
            for (int sc = 0; sc < 4; sc++) begin
               wr(4'h4, 32'd1 << (16 + 2*k + (prior ? 1 : 0)));
               exp_ie[k] = prior[0];
               wr(4'h4, ({30'd0, sc[1:0]}) << (16 + 2*k));
               if (sc == 2) exp_ie[k] = 1'b1;
               else if (sc == 1) exp_ie[k] = 1'b0;
               rd(4'h4, d);
               if (sc == 3 || sc == 0) chk("R7 pair hold", d, ctl_img(exp_ie, 32'd0));
               else                    chk("R6 pair set/clear", d, ctl_img(exp_ie, 32'd0));
            end
         end
      end

      // R8 fields
      wr(4'h4, 32'h0000_C00D);
      rd(4'h4, d);
      chk("R8 ctl fields", d, ctl_img(exp_ie, 32'h0000_C00D));
      chk("R8 cfg ports", {26'd0, cfg_mode, cfg_dev_to_mem, cfg_burst, cfg_fifo_off}, {26'd0, 3'd5, 1'b1, 1'b1, 1'b1});
      wr(4'h4, 32'h0000_3FF2);
      rd(4'h4, d);
      chk("R8 reserved bits read 0", d, ctl_img(exp_ie, 32'h0000_0002));

      // R3 / R9 running and lock
      wr(4'h0, 32'h1);
      chk("R3 start sets running", {31'd0, chan_running}, 32'd1);
      wr(4'h4, 32'h0000_0005);
      rd(4'h4, d);
      chk("R9 ctl locked", d, ctl_img(exp_ie, 32'h0000_0002));
      pulse_ev(4'b0001);
      chk("R3 done clears running", {31'd0, chan_running}, 32'd0);
      wr(4'h0, 32'h2);
      chk("R3 continue sets running", {31'd0, chan_running}, 32'd1);
      wr(4'h0, 32'h8);
      chk("R3 abort clears running", {31'd0, chan_running}, 32'd0);
      wr(4'h0, 32'h1);
      wr(4'h0, 32'h4);
      chk("R3 stop clears running", {31'd0, chan_running}, 32'd0);
      wr(4'h0, 32'h8000_0001);
      chk("R3 reset beats start", {31'd0, chan_running}, 32'd0);
      wr(4'h4, 32'h0000_0005);
      rd(4'h4, d);
      chk("R9 ctl writable when idle", d, 32'h0000_0005);

      // R4 / R5 latching and clears
      pulse_ev(4'b1111);
      repeat (2) @(negedge clk);
      rd(4'h8, d);
      chk("R4 all flags latched", d, 32'h020A_8200);
      wr(4'h0, 32'h80);
      rd(4'h8, d); chk("R5 clear done", d, 32'h000A_8200);
      wr(4'h0, 32'h20);
      rd(4'h8, d); chk("R5 clear link", d, 32'h0002_8200);
      wr(4'h0, 32'h40);
      rd(4'h8, d); chk("R5 clear ring, xerr kept", d, 32'h0000_8200);
      @(negedge clk);
      ev_done = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h80;
      @(negedge clk);
      ev_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(4'h8, d); chk("R5 event beats clear", d, 32'h0200_8200);

      // R11 channel reset
      wr(4'h4, 32'hAAAA_C00B);
      wr(4'h0, 32'h8000_0000);
      rd(4'h8, d); chk("R11 status cleared", d, 32'd0);
      rd(4'h4, d); chk("R11 enables cleared, fields kept", d, 32'h0000_C00B);

      // R10 every enable mask against every event combination
      for (int en = 0; en < 16; en++) begin
         for (int ev = 0; ev < 8; ev++) begin
            logic [31:0] cw;
            logic exp_int;
            wr(4'h0, 32'h8000_0000);
            cw = 32'd0;
            if (en[0]) cw[31] = 1'b1;
            if (en[1]) cw[25] = 1'b1;
            if (en[2]) cw[19] = 1'b1;
            if (en[3]) cw[17] = 1'b1;
            wr(4'h4, cw);
            pulse_ev({1'b0, ev[2:0]});
            exp_int = en[0] & ((en[1] & ev[0]) | (en[2] & ev[1]) | (en[3] & ev[2]));
            chk("R10 irq", {31'd0, irq}, {31'd0, exp_int});
            rd(4'h8, d);
            chk("R10 status", d, {exp_int, 5'd0, ev[0], 5'd0, ev[1], 1'b0, ev[2], 17'd0});
         end
      end

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule